// File: doc/BRIEF.md
# PIPE Lane Reset Release Sequencer

This block sits on the controller side of a PIPE-style PHY lane. It brings the lane out of reset and into the active power state, one step at a time, and moves to the next step only when the PHY reports the matching handshake. It runs entirely on the transmit clock that the PHY supplies. The asynchronous system reset reaches that clock through a multi-flop reset synchroniser before any state machine uses it.

The order of steps is fixed. While the lane PCS is held in reset, the block waits for transfer-enable. It then releases the PCS reset with PowerDown at P1 and waits for the first rising PhyStatus edge, which marks the end of receiver detect. Next it accepts CDR lock. After that it requests P0 and waits for a fresh PhyStatus edge that acknowledges the change. Last, it requires both CDR lock and CDR-lock-to-data before it raises link-ready.

Each wait step has a programmable timeout. When a timeout expires, the block sets a sticky error flag, records the code of the stalled step and restarts from the reset step. If lock is lost once the lane is ready, ready drops and the sequence restarts.

Top module: `lane_rst_seq`

## Requirements
- R1: In the reset step (state code 0), `pcs_rst_n` is 0 and `power_down` is P1 (2'b10). `pcs_rst_n` goes to 1 only after a clock edge at which `xfer_en` was sampled high.
- R2: `sys_rst_n` is asynchronous and passes through a synchroniser of SYNC_STAGES flops. After its release, the sequence first acts on `xfer_en` at the clock edge that follows the SYNC_STAGES edges of the synchroniser.
- R3: PhyStatus is edge detected against a registered copy. A level that stays high over many cycles counts as one acknowledgement. A second acknowledgement needs the level to fall and then rise again.
- R4: `power_down` only ever shows P1 (2'b10) or P0 (2'b00). It goes from P1 to P0 only at the edge where CDR lock is accepted in P1, and it returns to P1 only through the reset step.
- R5: In the detect step (code 1), CDR lock is ignored until the first PhyStatus rising edge has been seen. In the P1 lock step (code 2), the block moves to P0 at the first edge with `cdr_lock` high.
- R6: After P0 is requested (code 3), the block waits for a new PhyStatus rising edge before it checks lock, whatever the lock inputs show.
- R7: `link_ready` (ready step, code 5) is entered from the data-lock step (code 4) only at an edge where both `cdr_lock` and `cdr_data_lock` are 1. If `cdr_data_lock` stays 0, `link_ready` stays 0.
- R8: In the ready step, an edge with `cdr_lock` or `cdr_data_lock` low moves the block to the reset step. On the next cycle `link_ready` and `pcs_rst_n` are 0 and `power_down` is P1.
- R9: A wait step (codes 1 to 4) times out when it sees no advance for `tmo_limit`+1 consecutive edges. On timeout, `seq_err` is set, `err_state` takes the code of the stalled step and the block returns to the reset step. If an advance and a timeout fall on the same edge, the advance wins.
- R10: `seq_err` stays set until a system reset. A system reset clears `seq_err` and `err_state` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk | input | 1 | PHY-provided transmit clock; all logic runs on it |
| sys_rst_n | input | 1 | Asynchronous active-low system reset from another domain |
| xfer_en | input | 1 | PHY transmit transfer-enable indication |
| phy_status | input | 1 | PHY PhyStatus level |
| cdr_lock | input | 1 | Receiver CDR lock status |
| cdr_data_lock | input | 1 | Receiver CDR locked-to-data status |
| tmo_limit | input | TMO_W | Wait-step timeout limit in cycles (expiry after limit+1 edges) |
| pcs_rst_n | output | 1 | Active-low lane PCS reset |
| power_down | output | 2 | PowerDown encoding: P0=00, P0s=01, P1=10, P2=11 |
| link_ready | output | 1 | Lane brought up and locked to data |
| seq_err | output | 1 | Sticky sequence timeout flag |
| err_state | output | 3 | State code of the most recently stalled wait step |

## Verification
The assertions assume that every input except `sys_rst_n` is synchronous to `tx_clk`. They also assume that `tmo_limit` stays constant while a wait step is running, and that PhyStatus goes low between two acknowledgements the block is meant to count. The stimulus respects these assumptions. It changes inputs only on the falling clock edge. It sets the timeout limit before each scenario and does not touch it during the scenario. It drops `phy_status` for at least one cycle before every intended new acknowledgement, except where it holds the level high on purpose to show that a held level is not counted twice.

// File: rtl/lane_rst_seq_pkg.sv
// Shared types for the lane reset release sequencer.
// State codes are visible on err_state, so their values are fixed.
package lane_rst_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,  // PCS held in reset, waiting for transfer-enable
        ST_DETECT    = 3'd1,  // reset released, waiting for first PhyStatus edge
        ST_P1_LOCK   = 3'd2,  // in P1, waiting for CDR lock
        ST_P0_ACK    = 3'd3,  // P0 requested, waiting for PhyStatus acknowledge
        ST_DATA_LOCK = 3'd4,  // waiting for lock and lock-to-data
        ST_READY     = 3'd5   // lane ready
    } seq_state_t;

    localparam logic [1:0] PD_P0  = 2'b00;
    localparam logic [1:0] PD_P0S = 2'b01;
    localparam logic [1:0] PD_P1  = 2'b10;
    localparam logic [1:0] PD_P2  = 2'b11;

endpackage

// File: rtl/lane_rst_sync.sv
// Reset synchroniser into the transmit clock domain.
// Assertion of the reset is asynchronous, release is synchronous after STAGES edges.
// Assumes STAGES >= 2. The reset flops are the only asynchronously reset flops in the block.
module lane_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic async_rst_n,
    output logic rst_n_sync
);

    logic [STAGES-1:0] chain_q;

    // Shift ones in after release; clear the whole chain at once on assertion.
    always_ff @(posedge clk or negedge async_rst_n) begin
        if (!async_rst_n) chain_q <= '0;
        else              chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end

    assign rst_n_sync = chain_q[STAGES-1];

    // R2: the synchronised release never appears while the source reset is active.
    a_r2_release_follows_source: assert property (@(posedge clk) disable iff (!async_rst_n)
        $rose(rst_n_sync) |-> $past(async_rst_n));

endmodule

// File: rtl/lane_edge_pulse.sv
// Rising-edge detector for the PhyStatus level.
// Compares the input with a registered copy and gives a single-cycle pulse per rise.
// Assumes the input is synchronous to clk.
module lane_edge_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic rise_pulse
);

    logic level_q;

    // Keep the previous-cycle level of the input.
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level_in;
    end

    assign rise_pulse = level_in && !level_q;

    // R3: two pulses never arrive back to back; the level has to fall in between.
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rise_pulse |=> !rise_pulse);

endmodule

// File: rtl/lane_wait_timer.sv
// Cycle counter for the timeout of the wait steps.
// It restarts from zero on request and saturates at its maximum.
// expired is high while the count equals the limit.
// Assumes the limit stays constant while a count is running.
module lane_wait_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic [W-1:0] limit,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    // Count cycles in the current wait step; clear on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)  cnt_q <= '0;
        else if (cnt_q != '1)   cnt_q <= cnt_q + 1'b1;
    end

    assign expired = (cnt_q == limit);

    // R9: the count starts again from zero after every restart.
    a_r9_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == '0));

endmodule

// File: rtl/lane_rst_seq.sv
// Lane reset release sequencer (top).
// Brings one PIPE lane from reset to P0 with CDR locked to data, following the handshake order
// transfer-enable -> PhyStatus (detect) -> CDR lock in P1 -> P0 with PhyStatus ack -> lock-to-data.
// Assumes every input except sys_rst_n is synchronous to tx_clk. Timed-out steps set a sticky
// error and restart the sequence.
module lane_rst_seq
    import lane_rst_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int TMO_W       = 8
) (
    input  logic             tx_clk,
    input  logic             sys_rst_n,
    input  logic             xfer_en,
    input  logic             phy_status,
    input  logic             cdr_lock,
    input  logic             cdr_data_lock,
    input  logic [TMO_W-1:0] tmo_limit,
    output logic             pcs_rst_n,
    output logic [1:0]       power_down,
    output logic             link_ready,
    output logic             seq_err,
    output logic [2:0]       err_state
);

    logic       rst_n_sync;
    logic       ps_rise;
    logic       tmo_hit;
    logic       timed;
    logic       tmo_fire;
    logic       lock_ok;
    logic       tmr_restart;
    seq_state_t state_q, state_nom, state_d;

    lane_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk         (tx_clk),
        .async_rst_n (sys_rst_n),
        .rst_n_sync  (rst_n_sync)
    );

    lane_edge_pulse u_ps_edge (
        .clk        (tx_clk),
        .rst_n      (rst_n_sync),
        .level_in   (phy_status),
        .rise_pulse (ps_rise)
    );

    assign timed       = (state_q inside {ST_DETECT, ST_P1_LOCK, ST_P0_ACK, ST_DATA_LOCK});
    assign lock_ok     = cdr_lock && cdr_data_lock;
    assign tmr_restart = (state_d != state_q) || !timed;

    lane_wait_timer #(.W(TMO_W)) u_timer (
        .clk     (tx_clk),
        .rst_n   (rst_n_sync),
        .restart (tmr_restart),
        .limit   (tmo_limit),
        .expired (tmo_hit)
    );

    // Pick the handshake-driven next step, then let a timeout override a stalled step.
    always_comb begin
        state_nom = state_q;
        unique case (state_q)
            ST_IDLE:      if (xfer_en)    state_nom = ST_DETECT;
            ST_DETECT:    if (ps_rise)    state_nom = ST_P1_LOCK;
            ST_P1_LOCK:   if (cdr_lock)   state_nom = ST_P0_ACK;
            ST_P0_ACK:    if (ps_rise)    state_nom = ST_DATA_LOCK;
            ST_DATA_LOCK: if (lock_ok)    state_nom = ST_READY;
            ST_READY:     if (!lock_ok)   state_nom = ST_IDLE;
            default:                      state_nom = ST_IDLE;
        endcase
        tmo_fire = timed && tmo_hit && (state_nom == state_q);
        state_d  = tmo_fire ? ST_IDLE : state_nom;
    end

    // Hold the current step.
    always_ff @(posedge tx_clk) begin
        if (!rst_n_sync) state_q <= ST_IDLE;
        else             state_q <= state_d;
    end

    // Sticky error flag and the code of the step that stalled.
    always_ff @(posedge tx_clk) begin
        if (!rst_n_sync) begin
            seq_err   <= 1'b0;
            err_state <= 3'd0;
        end else if (tmo_fire) begin
            seq_err   <= 1'b1;
            err_state <= state_q;
        end
    end

    assign pcs_rst_n  = (state_q != ST_IDLE);
    assign power_down = (state_q inside {ST_P0_ACK, ST_DATA_LOCK, ST_READY}) ? PD_P0 : PD_P1;
    assign link_ready = (state_q == ST_READY);

    // R1: PCS reset is released only after transfer-enable was sampled.
    a_r1_release_after_xfer: assert property (@(posedge tx_clk) disable iff (!rst_n_sync)
        $rose(pcs_rst_n) |-> $past(xfer_en));

    // R4: only P1 and P0 are ever driven.
    a_r4_pd_legal: assert property (@(posedge tx_clk) disable iff (!rst_n_sync)
        (power_down == PD_P1) || (power_down == PD_P0));

    // R4: the move to P0 happens only when CDR lock was present.
    a_r4_p0_after_lock: assert property (@(posedge tx_clk) disable iff (!rst_n_sync)
        (!$stable(power_down) && power_down == PD_P0) |-> $past(cdr_lock));

    // R7: ready rises only after lock and lock-to-data were both seen.
    a_r7_ready_needs_data_lock: assert property (@(posedge tx_clk) disable iff (!rst_n_sync)
        $rose(link_ready) |-> $past(cdr_lock && cdr_data_lock));

    // R8: losing lock while ready drops ready and reasserts PCS reset.
    a_r8_lock_loss_restart: assert property (@(posedge tx_clk) disable iff (!rst_n_sync)
        (link_ready && !(cdr_lock && cdr_data_lock)) |=> (!link_ready && !pcs_rst_n));

    // R9: a new error sends the lane back to reset with a wait-step code recorded.
    a_r9_timeout_restart: assert property (@(posedge tx_clk) disable iff (!rst_n_sync)
        $rose(seq_err) |-> (!pcs_rst_n && err_state != 3'd0 && err_state != 3'd5));

    // R10: the error flag never clears without a system reset.
    a_r10_sticky: assert property (@(posedge tx_clk) disable iff (!rst_n_sync)
        $past(seq_err) |-> seq_err);

endmodule

// File: tb/lane_rst_seq_tb_top.sv
`timescale 1ns/1ps
module lane_rst_seq_tb_top;

    localparam int STG = 2;
    localparam int TW  = 8;

    logic          clk = 1'b0;
    logic          sys_rst_n = 1'b0;
    logic          xfer_en = 1'b0;
    logic          phy_status = 1'b0;
    logic          cdr_lock = 1'b0;
    logic          cdr_data_lock = 1'b0;
    logic [TW-1:0] tmo_limit = 8'd20;
    logic          pcs_rst_n;
    logic [1:0]    power_down;
    logic          link_ready;
    logic          seq_err;
    logic [2:0]    err_state;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    lane_rst_seq #(.SYNC_STAGES(STG), .TMO_W(TW)) dut_i (
        .tx_clk        (clk),
        .sys_rst_n     (sys_rst_n),
        .xfer_en       (xfer_en),
        .phy_status    (phy_status),
        .cdr_lock      (cdr_lock),
        .cdr_data_lock (cdr_data_lock),
        .tmo_limit     (tmo_limit),
        .pcs_rst_n     (pcs_rst_n),
        .power_down    (power_down),
        .link_ready    (link_ready),
        .seq_err       (seq_err),
        .err_state     (err_state)
    );

    // Behavioural reference: step number, wait counter, previous PhyStatus, error record.
    int m_step = 0;
    int m_wait = 0;
    int m_rel  = 0;
    int m_code = 0;
    bit m_prev = 0;
    bit m_err  = 0;
    bit m_live = 0;

    always @(negedge sys_rst_n) m_rel = 0;

    always @(posedge clk) begin
        int nxt;
        bit rise;
        rise = phy_status && !m_prev;
        if (m_rel < STG) begin
            m_step = 0; m_wait = 0; m_prev = 0; m_err = 0; m_code = 0;
        end else begin
            m_prev = phy_status;
            nxt = m_step;
            if (m_step == 0 && xfer_en) nxt = 1;
            if (m_step == 1 && rise) nxt = 2;
            if (m_step == 2 && cdr_lock) nxt = 3;
            if (m_step == 3 && rise) nxt = 4;
            if (m_step == 4 && cdr_lock && cdr_data_lock) nxt = 5;
            if (m_step == 5 && !(cdr_lock && cdr_data_lock)) nxt = 0;
            if (m_step >= 1 && m_step <= 4 && nxt == m_step && m_wait == int'(tmo_limit)) begin
                m_err = 1; m_code = m_step; nxt = 0;
            end
            if (nxt != m_step) m_wait = 0;
            else if (m_wait < 255) m_wait = m_wait + 1;
            m_step = nxt;
        end
        if (sys_rst_n && m_rel < STG) m_rel = m_rel + 1;
        m_live = 1;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare every output with the reference on each falling edge.
    always @(negedge clk) begin
        if (m_live) begin
            chk("R1", "pcs_rst_n", int'(pcs_rst_n), (m_step != 0) ? 1 : 0);
            chk("R4", "power_down", int'(power_down), (m_step >= 3) ? 0 : 2);
            chk("R7", "link_ready", int'(link_ready), (m_step == 5) ? 1 : 0);
            chk("R9", "seq_err", int'(seq_err), int'(m_err));
            chk("R9", "err_state", int'(err_state), m_code);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reset_with(input int lim);
        @(negedge clk);
        sys_rst_n = 1'b0;
        tmo_limit = 8'(lim);
        cyc(4);
        sys_rst_n = 1'b1;
    endtask

    initial begin
        // Reset state, then the synchroniser delay (R1, R2).
        cyc(4);
        chk("R1", "reset pcs_rst_n", int'(pcs_rst_n), 0);
        chk("R1", "reset power_down P1", int'(power_down), 2);
        chk("R10", "reset seq_err", int'(seq_err), 0);
        xfer_en = 1'b1;
        tmo_limit = 8'd3;
        cyc(1);
        sys_rst_n = 1'b1;
        for (int i = 0; i < STG; i++) begin
            cyc(1);
            chk("R2", "pcs held during sync", int'(pcs_rst_n), 0);
        end
        cyc(1);
        chk("R2", "pcs released after sync", int'(pcs_rst_n), 1);
        // Detect step times out after limit+1 edges without PhyStatus (R9).
        cyc(3);
        chk("R9", "no error before limit", int'(seq_err), 0);
        cyc(1);
        chk("R9", "error at limit+1", int'(seq_err), 1);
        chk("R9", "stalled code detect", int'(err_state), 1);
        chk("R9", "back to reset", int'(pcs_rst_n), 0);

        // System reset clears the sticky record (R10).
        reset_with(20);
        cyc(STG + 1);
        chk("R10", "seq_err cleared", int'(seq_err), 0);
        chk("R10", "err_state cleared", int'(err_state), 0);
        chk("R1", "released again", int'(pcs_rst_n), 1);

        // Lock before detect acknowledgement is ignored (R5).
        cdr_lock = 1'b1;
        cdr_data_lock = 1'b1;
        cyc(5);
        chk("R5", "lock ignored before PhyStatus", int'(power_down), 2);
        phy_status = 1'b1;   // held high for the rest of the P0 wait (R3)
        cyc(1);
        cyc(1);
        chk("R4", "moved to P0 after lock", int'(power_down), 0);
        cyc(4);
        chk("R6", "held PhyStatus not a new ack", int'(link_ready), 0);
        chk("R3", "still waiting in P0", int'(power_down), 0);
        phy_status = 1'b0;
        cyc(1);
        phy_status = 1'b1;
        cyc(1);
        chk("R6", "ack taken, not yet ready", int'(link_ready), 0);
        cyc(1);
        chk("R7", "ready with data lock", int'(link_ready), 1);
        phy_status = 1'b0;
        cyc(3);
        chk("R7", "ready stays", int'(link_ready), 1);

        // Loss of lock restarts (R8).
        cdr_lock = 1'b0;
        cyc(1);
        chk("R8", "ready dropped", int'(link_ready), 0);
        chk("R8", "pcs reset reasserted", int'(pcs_rst_n), 0);
        chk("R8", "power_down back to P1", int'(power_down), 2);

        // Lock-to-data never arrives (R7), then the data-lock step times out (R9, R10).
        cdr_lock = 1'b1;
        cdr_data_lock = 1'b0;
        cyc(2);
        phy_status = 1'b1;
        cyc(2);
        phy_status = 1'b0;
        cyc(1);
        phy_status = 1'b1;
        cyc(1);
        phy_status = 1'b0;
        cyc(10);
        chk("R7", "no ready without data lock", int'(link_ready), 0);
        chk("R7", "waiting in P0 for data lock", int'(power_down), 0);
        cyc(15);
        chk("R9", "data-lock step timed out", int'(seq_err), 1);
        chk("R9", "stalled code data lock", int'(err_state), 4);
        cyc(60);
        chk("R10", "error still sticky", int'(seq_err), 1);
        chk("R9", "latest stalled code detect", int'(err_state), 1);
        reset_with(20);
        cyc(STG + 1);
        chk("R10", "cleared by system reset", int'(seq_err), 0);
        cyc(2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule